// File: doc/BRIEF.md
# Block Register Transfer Address Sequencer

This sequencer turns one block load or store request into a stream of single-word memory beats. It is given a register selection mask, a base address, a stepping mode, a load/store flag, a writeback flag and the index of the register that supplied the base. One start pulse launches the run. The block then issues one beat per clock, and each beat carries a word address and the index of the register to move. After the last beat it presents the updated base value for the register file and pulses done.

The registers always leave or arrive in ascending index order. The lowest-numbered register goes to the lowest address. The stepping mode decides only where that address window sits relative to the base and which way the base moves. The four modes cover the usual stack conventions. A full stack points at the last slot written and an empty stack points at the first free one. An ascending stack grows upward in memory and a descending stack grows downward.

The block follows two rules about the base register. On a store where the base register is also in the list and is its lowest member, the beat for that register is flagged so that the datapath stores the original base rather than an updated one. When the base comes from register 15, the program counter, no writeback is requested.

Top module: `blk_xfer_seq`

## Requirements
- R1: After reset, busy, xfer_valid, done and wb_valid are all low.
- R2: A start pulse sampled while idle launches a run. For a mask with n set bits there are exactly n beats on consecutive cycles, beginning the cycle after start. Each set bit appears once as xfer_idx, in ascending order. xfer_load repeats the load flag latched at start.
- R3: The mode encoding is 00 increment-after, 01 increment-before, 10 decrement-after, 11 decrement-before. Beat i (counting from 0) has address base+4i, base+4+4i, base-4n+4+4i and base-4n+4i respectively, taken modulo 2^32.
- R4: done is high for exactly one cycle, the cycle right after the last beat. An empty mask produces no beats, and done is high in the cycle after start.
- R5: While done is high, wb_base equals base+4n for the increment modes and base-4n for the decrement modes.
- R6: wb_valid is high exactly in the done cycle, when the writeback flag was set at start and the base index was not 15.
- R7: xfer_base_orig is high on a beat only for a store, on the beat whose index equals the base index, and only when that index is the lowest set bit of the mask. It is low on every other beat.
- R8: A start pulse arriving while busy (during beats or the done cycle) is ignored. The run in progress keeps its beats and its final base, and no second run follows.
- R9: Inputs other than start are sampled only at an accepted start. Changing them during a run has no effect on the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch pulse, taken only when idle |
| reg_mask | input | 16 | Register selection, bit i selects register i |
| base_in | input | 32 | Base address |
| mode | input | 2 | Stepping mode (see R3) |
| is_load | input | 1 | 1 = load, 0 = store |
| wb_en | input | 1 | Request base writeback |
| base_idx | input | 4 | Index of the register holding the base |
| busy | output | 1 | Run in progress, including the done cycle |
| xfer_valid | output | 1 | Beat strobe |
| xfer_addr | output | 32 | Word address of the beat |
| xfer_idx | output | 4 | Register index of the beat |
| xfer_load | output | 1 | Direction of the beat |
| xfer_base_orig | output | 1 | Store the pre-run base value on this beat |
| done | output | 1 | One-cycle end-of-run pulse |
| wb_valid | output | 1 | Write wb_base to the base register |
| wb_base | output | 32 | Final base value |

## Verification
The bench targets the following corner cases and the failure each would expose:
- Decrement modes with a small base, where the window wraps below zero. A sign or width slip moves every address there.
- The full 16-register mask and single-bit masks at either end. An off-by-one in the end-of-run test shows up as one beat too many or too few.
- The empty mask. A design that handles it wrongly hangs or emits a stray beat.
- A base register that is lowest, not lowest, or index 15. A wrong lowest-bit test raises the original-base flag on the wrong beat, and a missing program-counter check requests writeback when it must not.
- A start pulse and changed inputs injected in the middle of a run. A design that does not ignore them restarts the run or corrupts the final base.

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq #(
  parameter int NREG       = 16,
  parameter int AW         = 32,
  parameter int WORD_BYTES = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [NREG-1:0]         reg_mask,
  input  logic [AW-1:0]           base_in,
  input  logic [1:0]              mode,
  input  logic                    is_load,
  input  logic                    wb_en,
  input  logic [$clog2(NREG)-1:0] base_idx,
  output logic                    busy,
  output logic                    xfer_valid,
  output logic [AW-1:0]           xfer_addr,
  output logic [$clog2(NREG)-1:0] xfer_idx,
  output logic                    xfer_load,
  output logic                    xfer_base_orig,
  output logic                    done,
  output logic                    wb_valid,
  output logic [AW-1:0]           wb_base
);
  localparam int IW     = $clog2(NREG);
  localparam int CW     = IW + 1;
  localparam int PC_IDX = NREG - 1;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DONE} st_t;

  st_t             st_q;
  logic [NREG-1:0] rem_q;
  logic [AW-1:0]   addr_q, final_q;
  logic            load_q, wb_q, orig_q;
  logic [IW-1:0]   bidx_q;

  logic [CW-1:0]   cnt;
  logic [AW-1:0]   span, first_addr, final_addr;
  logic [IW-1:0]   cur_idx;
  logic            base_lowest, last_beat;
  logic            dec, pre;

  always_comb begin
    cnt = '0;
    for (int i = 0; i < NREG; i++) cnt = cnt + CW'(reg_mask[i]);
  end

  always_comb begin
    cur_idx = '0;
    for (int i = NREG - 1; i >= 0; i--)
      if (rem_q[i]) cur_idx = IW'(i);
  end

  assign dec  = mode[1];
  assign pre  = mode[0];
  assign span = AW'(cnt) * AW'(WORD_BYTES);

  assign first_addr = dec ? (base_in - span + (pre ? '0 : AW'(WORD_BYTES)))
                          : (base_in + (pre ? AW'(WORD_BYTES) : '0));
  assign final_addr = dec ? (base_in - span) : (base_in + span);

  assign base_lowest = reg_mask[base_idx] &&
                       ((reg_mask & ~({NREG{1'b1}} << base_idx)) == '0);
  assign last_beat   = (rem_q & (rem_q - 1'b1)) == '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      rem_q   <= '0;
      addr_q  <= '0;
      final_q <= '0;
      load_q  <= 1'b0;
      wb_q    <= 1'b0;
      orig_q  <= 1'b0;
      bidx_q  <= '0;
    end else begin
      unique case (st_q)
        S_IDLE: if (start) begin
          rem_q   <= reg_mask;
          addr_q  <= first_addr;
          final_q <= final_addr;
          load_q  <= is_load;
          wb_q    <= wb_en && (base_idx != IW'(PC_IDX));
          orig_q  <= !is_load && base_lowest;
          bidx_q  <= base_idx;
          st_q    <= (reg_mask == '0) ? S_DONE : S_RUN;
        end
        S_RUN: begin
          rem_q  <= rem_q & (rem_q - 1'b1);
          addr_q <= addr_q + AW'(WORD_BYTES);
          if (last_beat) st_q <= S_DONE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign busy           = st_q != S_IDLE;
  assign xfer_valid     = st_q == S_RUN;
  assign xfer_addr      = addr_q;
  assign xfer_idx       = cur_idx;
  assign xfer_load      = load_q;
  assign xfer_base_orig = xfer_valid && orig_q && (cur_idx == bidx_q);
  assign done           = st_q == S_DONE;
  assign wb_valid       = done && wb_q;
  assign wb_base        = final_q;

  // R2
  idx_ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid && $past(xfer_valid) |-> xfer_idx > $past(xfer_idx));

  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid && $past(xfer_valid) |-> xfer_addr == $past(xfer_addr) + AW'(WORD_BYTES));

  // R4
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid && $countones(rem_q) == 1 |=> done && !xfer_valid);

  // R4
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);

  // R6
  wb_in_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> done);

  // R7
  orig_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_base_orig |-> xfer_valid && !xfer_load);

  // R8
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done |=> $stable(wb_base));

  // R4
  beat_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({xfer_valid, done}));
endmodule

// File: tb/blk_xfer_seq_test.sv
`timescale 1ns/1ps
module blk_xfer_seq_test;
  logic        clk = 0, rst_n = 0, start = 0;
  logic [15:0] reg_mask = '0;
  logic [31:0] base_in = '0;
  logic [1:0]  mode = '0;
  logic        is_load = 0, wb_en = 0;
  logic [3:0]  base_idx = '0;
  logic        busy, xfer_valid, xfer_load, xfer_base_orig, done, wb_valid;
  logic [31:0] xfer_addr, wb_base;
  logic [3:0]  xfer_idx;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  blk_xfer_seq uut (.*);

  task automatic chk(input string r, input logic [31:0] a, input logic [31:0] e);
    checks++;
    if (a !== e) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, a, e);
    end
  endtask

  function automatic logic [31:0] exp_first(logic [31:0] b, logic [1:0] md, int n);
    case (md)
      2'b00: return b;
      2'b01: return b + 32'd4;
      2'b10: return b - 32'(4*n) + 32'd4;
      default: return b - 32'(4*n);
    endcase
  endfunction

  function automatic logic [31:0] exp_final(logic [31:0] b, logic [1:0] md, int n);
    return md[1] ? b - 32'(4*n) : b + 32'(4*n);
  endfunction

  function automatic logic is_lowest(logic [15:0] m, logic [3:0] bi);
    for (int j = 0; j < 16; j++) if (m[j]) return 4'(j) == bi;
    return 1'b0;
  endfunction

  task automatic run(input logic [15:0] m, input logic [31:0] b, input logic [1:0] md,
                     input logic ld, input logic wb, input logic [3:0] bi, input bit inject);
    int n = $countones(m);
    int k = 0;
    logic [31:0] a0 = exp_first(b, md, n);
    reg_mask = m; base_in = b; mode = md; is_load = ld; wb_en = wb; base_idx = bi;
    start = 1;
    @(negedge clk);
    start = 0;
    reg_mask = 16'($urandom); base_in = $urandom; mode = 2'($urandom);
    is_load = 1'($urandom); wb_en = 1'($urandom); base_idx = 4'($urandom);
    for (int j = 0; j < 16; j++) begin
      if (!m[j]) continue;
      chk("R2 valid", 32'(xfer_valid), 1);
      chk("R2 idx", 32'(xfer_idx), 32'(j));
      chk("R2 load", 32'(xfer_load), 32'(ld));
      chk("R3 addr R9", xfer_addr, a0 + 32'(4*k));
      chk("R7 orig", 32'(xfer_base_orig), 32'(!ld && 4'(j) == bi && is_lowest(m, bi)));
      if (inject && k == 0) start = 1;
      k++;
      @(negedge clk);
      start = 0;
    end
    chk("R4 done", 32'(done), 1);
    chk("R4 no beat", 32'(xfer_valid), 0);
    chk("R5 wb_base", wb_base, exp_final(b, md, n));
    chk("R6 wb_valid", 32'(wb_valid), 32'(wb && bi != 4'd15));
    if (inject) start = 1;
    @(negedge clk);
    start = 0;
    chk("R8 idle after done", 32'(busy), 0);
    chk("R4 done single", 32'(done), 0);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    chk("R1 busy", 32'(busy), 0);
    chk("R1 valid", 32'(xfer_valid), 0);
    chk("R1 done", 32'(done), 0);
    chk("R1 wb_valid", 32'(wb_valid), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 idle after release", 32'(busy), 0);

    run(16'h0000, 32'h1000, 2'b11, 0, 1, 4'd3, 0);
    run(16'hFFFF, 32'h2000, 2'b00, 1, 1, 4'd0, 0);
    run(16'hFFFF, 32'h0000_0010, 2'b11, 0, 1, 4'd5, 0);
    run(16'h8000, 32'h0000_0000, 2'b10, 0, 1, 4'd15, 0);
    run(16'h0001, 32'hFFFF_FFFC, 2'b01, 1, 1, 4'd0, 0);
    run(16'h00F0, 32'h4000, 2'b11, 0, 1, 4'd4, 0);
    run(16'h00F0, 32'h4000, 2'b11, 0, 1, 4'd6, 0);
    run(16'h00F0, 32'h4000, 2'b10, 1, 1, 4'd4, 0);
    run(16'h8421, 32'h8000, 2'b01, 0, 1, 4'd15, 1);
    run(16'h0003, 32'h0000_0004, 2'b10, 0, 0, 4'd1, 1);
    run(16'h0000, 32'h1234_5678, 2'b00, 0, 1, 4'd2, 0);

    for (int t = 0; t < 400; t++) begin
      logic [15:0] m = 16'($urandom);
      if (t % 4 == 1) m = m & 16'($urandom) & 16'($urandom);
      if (t % 17 == 0) m = '0;
      run(m, $urandom & 32'hFFFF_FFFC, 2'($urandom), 1'($urandom), 1'($urandom),
          4'($urandom), bit'($urandom));
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule